// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host that only issues 64-bit register accesses a way to reach targets on a 32-bit internal request/acknowledge bus. The host sees four registers, picked by two bits of its byte address: control, reset, status and data. Write data is staged in the data register first. A write to the control register then starts exactly one internal-bus transaction. The direction, the byte count and the target address all come from fields of that control word.

Completion is reported through the status register. It carries a done flag and, for reads, the returned 32 bits. Reading the status register clears it. The host polls status until the done flag shows, and the poll that sees the flag also consumes it. Field positions follow MSB-first numbering: bit 0 is the most significant bit of the 64-bit word. The bridge converts between that numbering and the byte-lane order of the internal bus, where the byte at the lowest address travels on the lowest lane.

Top module: `host_ib_bridge`

## Requirements
- R1: Host address bits [4:3] select the register: 0 is control, 1 is reset, 2 is status and 3 is data. A read of control or reset returns zero. A write to status or reset changes no register.
- R2: A data-register write stores bits [63:32] of the written word. A data-register read returns the stored value in bits [63:32] with bits [31:0] zero.
- R3: A control write with a legal size starts one bus transaction. The fields are taken from the control word in MSB-first numbering, where bit n sits at LSB index 63-n:
  - the read flag is bit 15 (LSB index 48), and 1 means read;
  - the byte count is bits 4..7 (LSB index 59:56), with bit 4 as its MSB;
  - the target address is bits 32..63 (LSB index 31:0).
- R4: A byte count above 8 is refused. No bus request is raised and the status register keeps its value. A count of exactly 8 is accepted.
- R5: When a read completes without error, status becomes the done flag (MSB-first bit 52, LSB index 11) together with the returned word at LSB index 57:26. The byte from bus lane 0 (ib_rdata[7:0], the lowest address) lands in the most significant byte of that field.
- R6: When a read completes with the error response, status becomes the done flag with the 32-bit data field all ones, which is 64'h03FF_FFFF_FC00_0800.
- R7: A write drives the staged data register onto the bus with its most significant byte on lane 0 (ib_wdata[7:0]). On completion status becomes the done flag alone (64'h800), whether or not the error response was given.
- R8: A status read returns the current contents and then leaves the register at zero.
- R9: The request and its fields are held steady from launch until the acknowledge. A control write made while a transaction is in flight, including in the acknowledge cycle, is dropped. The done flag appears only after the acknowledge.
- R10: When a status read and a bus acknowledge fall in the same cycle, the read returns the contents from before the acknowledge. The new completion word is then kept for the next read.
- R11: Read data appears on host_rdata with host_rvalid one cycle after the read request. After reset, status and data are zero and no bus request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | HAW | Host byte address; bits [4:3] select the register |
| host_wdata | input | 64 | Host write word |
| host_rdata | output | 64 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| ib_req | output | 1 | Bus request, held until acknowledge |
| ib_we | output | 1 | Bus direction, 1 for write |
| ib_addr | output | IB_AW | Bus target address |
| ib_size | output | SZW | Byte count of the transaction |
| ib_wdata | output | IB_DW | Write data, lane 0 carries the lowest-address byte |
| ib_ack | input | 1 | Bus acknowledge, one cycle |
| ib_err | input | 1 | Error response, valid with ib_ack |
| ib_rdata | input | IB_DW | Read data, valid with ib_ack |

## Verification
The status register has two writers that can act in the same cycle. One is the clear that a host status read performs. The other is the completion word loaded by a bus acknowledge. The bench times a status read to be sampled on the exact edge that samples the acknowledge. It then checks two things: the returned word is the older status contents, and the following read returns the new completion word. A second overlap, a control write landing on the acknowledge edge, is judged by whether any further bus request appears. The behavioural reference model follows both cases every cycle.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int HOST_W = 64;

  // Convert an MSB-first bit number to an LSB-based index.
  function automatic int lsb_of(input int msb_first);
    return HOST_W - 1 - msb_first;
  endfunction

  localparam int RD_FLAG_IDX = lsb_of(15);
  localparam int SIZE_HI_IDX = lsb_of(4);
  localparam int SIZE_LO_IDX = lsb_of(7);
  localparam int ADDR_HI_IDX = lsb_of(32);
  localparam int DONE_IDX    = lsb_of(52);
  localparam int RD_SHIFT    = 26;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/ibr_host_decode.sv
module ibr_host_decode
  import ibr_pkg::*;
#(
  parameter int HAW   = 8,
  parameter int IB_AW = 32,
  parameter int SZW   = 4,
  parameter int IB_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [HAW-1:0]    host_addr,
  input  logic [63:0]       host_wdata,
  input  logic [63:0]       stat_q,
  input  logic [IB_DW-1:0]  data_q,
  output logic              ctl_wr,
  output logic              ctl_rd_flag,
  output logic [SZW-1:0]    ctl_size,
  output logic [IB_AW-1:0]  ctl_addr,
  output logic              data_wr,
  output logic [IB_DW-1:0]  data_in,
  output logic              stat_rd,
  output logic [63:0]       host_rdata,
  output logic              host_rvalid
);

  reg_sel_e sel;
  logic     rd_acc;
  logic     unused_bits;

  assign sel    = reg_sel_e'(host_addr[4:3]);
  assign rd_acc = host_valid && !host_write;

  assign ctl_wr      = host_valid && host_write && (sel == SEL_CTL);
  assign data_wr     = host_valid && host_write && (sel == SEL_DATA);
  assign stat_rd     = rd_acc && (sel == SEL_STAT);
  assign ctl_rd_flag = host_wdata[RD_FLAG_IDX];
  assign ctl_size    = host_wdata[SIZE_HI_IDX -: SZW];
  assign ctl_addr    = host_wdata[ADDR_HI_IDX -: IB_AW];
  assign data_in     = host_wdata[63 -: IB_DW];

  assign unused_bits = ^{host_addr, host_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_acc;
      if (rd_acc) begin
        unique case (sel)
          SEL_STAT: host_rdata <= stat_q;
          SEL_DATA: host_rdata <= {data_q, {(64-IB_DW){1'b0}}};
          default:  host_rdata <= '0;
        endcase
      end
    end
  end

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && (sel == SEL_CTL || sel == SEL_RST)) |=> (host_rvalid && host_rdata == '0)) // R1
    else $error("control/reset read not zero");

  AST_DATA_READ_LOW: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && sel == SEL_DATA) |=> (host_rdata[63-IB_DW:0] == '0)) // R2
    else $error("data read low half not zero");

endmodule

// File: rtl/ibr_cmd_engine.sv
module ibr_cmd_engine
  import ibr_pkg::*;
#(
  parameter int IB_AW     = 32,
  parameter int IB_DW     = 32,
  parameter int SZW       = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              ctl_rd_flag,
  input  logic [SZW-1:0]    ctl_size,
  input  logic [IB_AW-1:0]  ctl_addr,
  input  logic [IB_DW-1:0]  stage_data,
  output logic              ib_req,
  output logic              ib_we,
  output logic [IB_AW-1:0]  ib_addr,
  output logic [SZW-1:0]    ib_size,
  output logic [IB_DW-1:0]  ib_wdata,
  input  logic              ib_ack,
  input  logic              ib_err,
  input  logic [IB_DW-1:0]  ib_rdata,
  output logic              cpl_valid,
  output logic [63:0]       cpl_word
);

  localparam int LANES = IB_DW / 8;

  logic              size_ok;
  logic              launch;
  logic [IB_DW-1:0]  lane_wdata;
  logic [IB_DW-1:0]  packed_rdata;

  assign size_ok = (ctl_size <= SZW'(MAX_BYTES));
  assign launch  = ctl_wr && !ib_req && size_ok;

  // Byte-lane swap: register MSB byte <-> lane 0 (lowest address).
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_wdata[8*k +: 8]              = stage_data[IB_DW-8-8*k +: 8];
    assign packed_rdata[IB_DW-8-8*k +: 8]    = ib_rdata[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_req   <= 1'b0;
      ib_we    <= 1'b0;
      ib_addr  <= '0;
      ib_size  <= '0;
      ib_wdata <= '0;
    end else if (launch) begin
      ib_req   <= 1'b1;
      ib_we    <= !ctl_rd_flag;
      ib_addr  <= ctl_addr;
      ib_size  <= ctl_size;
      ib_wdata <= lane_wdata;
    end else if (ib_req && ib_ack) begin
      ib_req   <= 1'b0;
    end
  end

  assign cpl_valid = ib_req && ib_ack;

  always_comb begin
    cpl_word           = '0;
    cpl_word[DONE_IDX] = 1'b1;
    if (!ib_we) begin
      cpl_word[RD_SHIFT +: IB_DW] = ib_err ? {IB_DW{1'b1}} : packed_rdata;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_size))) // R9
    else $error("request dropped or changed before ack");

  AST_NO_OVERSIZE: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ib_req && !size_ok) |=> !ib_req) // R4
    else $error("oversize command launched");

  AST_LAUNCH_FIELDS: assert property (@(posedge clk) disable iff (rst)
    launch |=> (ib_req && ib_addr == $past(ctl_addr) && ib_size == $past(ctl_size))) // R3
    else $error("launch fields mismatch");

endmodule

// File: rtl/ibr_status_latch.sv
module ibr_status_latch
  import ibr_pkg::*;
#(
  parameter int IB_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              data_wr,
  input  logic [IB_DW-1:0]  data_in,
  input  logic              cpl_valid,
  input  logic [63:0]       cpl_word,
  output logic [63:0]       stat_q,
  output logic [IB_DW-1:0]  data_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (cpl_valid) begin
      stat_q <= cpl_word;
    end else if (stat_rd) begin
      stat_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (data_wr) begin
      data_q <= data_in;
    end
  end

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !cpl_valid) |=> (stat_q == '0)) // R8
    else $error("status not cleared by read");

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[DONE_IDX]) |-> $past(cpl_valid)) // R9
    else $error("done flag without ack");

  AST_CPL_KEPT: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |=> stat_q[DONE_IDX]) // R10
    else $error("completion lost");

endmodule

// File: rtl/host_ib_bridge.sv
module host_ib_bridge
  import ibr_pkg::*;
#(
  parameter int HAW       = 8,
  parameter int IB_AW     = 32,
  parameter int IB_DW     = 32,
  parameter int SZW       = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [HAW-1:0]    host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              host_rvalid,
  output logic              ib_req,
  output logic              ib_we,
  output logic [IB_AW-1:0]  ib_addr,
  output logic [SZW-1:0]    ib_size,
  output logic [IB_DW-1:0]  ib_wdata,
  input  logic              ib_ack,
  input  logic              ib_err,
  input  logic [IB_DW-1:0]  ib_rdata
);

  logic              ctl_wr, ctl_rd_flag, data_wr, stat_rd, cpl_valid;
  logic [SZW-1:0]    ctl_size;
  logic [IB_AW-1:0]  ctl_addr;
  logic [IB_DW-1:0]  data_in, data_q;
  logic [63:0]       stat_q, cpl_word;

  ibr_host_decode #(.HAW(HAW), .IB_AW(IB_AW), .SZW(SZW), .IB_DW(IB_DW)) u_decode (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .stat_q(stat_q), .data_q(data_q),
    .ctl_wr(ctl_wr), .ctl_rd_flag(ctl_rd_flag), .ctl_size(ctl_size),
    .ctl_addr(ctl_addr), .data_wr(data_wr), .data_in(data_in),
    .stat_rd(stat_rd), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  ibr_cmd_engine #(.IB_AW(IB_AW), .IB_DW(IB_DW), .SZW(SZW), .MAX_BYTES(MAX_BYTES)) u_engine (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_rd_flag(ctl_rd_flag), .ctl_size(ctl_size),
    .ctl_addr(ctl_addr), .stage_data(data_q),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_size(ib_size),
    .ib_wdata(ib_wdata), .ib_ack(ib_ack), .ib_err(ib_err), .ib_rdata(ib_rdata),
    .cpl_valid(cpl_valid), .cpl_word(cpl_word)
  );

  ibr_status_latch #(.IB_DW(IB_DW)) u_status (
    .clk(clk), .rst(rst),
    .stat_rd(stat_rd), .data_wr(data_wr), .data_in(data_in),
    .cpl_valid(cpl_valid), .cpl_word(cpl_word),
    .stat_q(stat_q), .data_q(data_q)
  );

endmodule

// File: tb/host_ib_bridge_bench.sv
module host_ib_bridge_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hv = 1'b0, hw = 1'b0;
  logic [7:0]  ha = '0;
  logic [63:0] hd = '0;
  logic [63:0] host_rdata;
  logic        host_rvalid;
  logic        ib_req, ib_we;
  logic [31:0] ib_addr, ib_wdata;
  logic [3:0]  ib_size;
  logic        ack = 1'b0, err = 1'b0;
  logic [31:0] rd = '0;

  int n_chk = 0, n_fail = 0;
  int lat = 2, cnt = 0, nreq = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_size;
  logic        cap_we;

  // Reference model state
  logic        m_busy = 0, m_we = 0, m_rvalid = 0;
  logic [31:0] m_addr = 0, m_wd = 0, m_data = 0;
  logic [3:0]  m_size = 0;
  logic [63:0] m_stat = 0, m_rdata = 0;

  always #5 clk = ~clk;

  host_ib_bridge u_host_ib_bridge (
    .clk(clk), .rst(rst), .host_valid(hv), .host_write(hw), .host_addr(ha),
    .host_wdata(hd), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_size(ib_size),
    .ib_wdata(ib_wdata), .ib_ack(ack), .ib_err(err), .ib_rdata(rd)
  );

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_stat = 0; m_data = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      logic [63:0] nstat;
      nstat = m_stat;
      m_rvalid = hv && !hw;
      if (hv && !hw) begin
        case (ha[4:3])
          2'd2: m_rdata = m_stat;
          2'd3: m_rdata = {m_data, 32'h0};
          default: m_rdata = 64'h0;
        endcase
        if (ha[4:3] == 2'd2) nstat = 64'h0;
      end
      if (m_busy && ack) begin
        nstat = 64'h800;
        if (!m_we) nstat[57:26] = err ? 32'hFFFF_FFFF : bswap(rd);
        m_busy = 0;
      end else if (hv && hw && ha[4:3] == 2'd0 && !m_busy && hd[59:56] <= 4'd8) begin
        m_busy = 1; m_we = !hd[48]; m_size = hd[59:56]; m_addr = hd[31:0];
        m_wd = bswap(m_data);
      end
      if (hv && hw && ha[4:3] == 2'd3) m_data = hd[63:32];
      m_stat = nstat;
    end
  end

  // Bus target model and per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      check("R11 rvalid", {63'h0, host_rvalid}, {63'h0, m_rvalid});
      if (m_rvalid) check("R11 rdata", host_rdata, m_rdata);
      check("R9 req", {63'h0, ib_req}, {63'h0, m_busy});
      if (m_busy) begin
        check("R3 bus fields", {27'h0, ib_we, ib_size, ib_addr}, {27'h0, m_we, m_size, m_addr});
        if (m_we) check("R7 wdata", {32'h0, ib_wdata}, {32'h0, m_wd});
      end
    end
    if (ack) begin
      ack = 0; cnt = 0;
    end else if (ib_req) begin
      cnt++;
      if (cnt >= lat) begin
        ack = 1; err = ib_addr[31];
        rd = {ib_addr[7:0] + 8'd3, ib_addr[7:0] + 8'd2, ib_addr[7:0] + 8'd1, ib_addr[7:0]} ^ 32'h5A5A5A5A;
        cap_addr = ib_addr; cap_wdata = ib_wdata; cap_size = ib_size; cap_we = ib_we;
        nreq++;
      end
    end
  end

  task automatic acc(input logic w, input logic [1:0] sel, input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    hv = 1; hw = w; ha = {3'b0, sel, 3'b101}; hd = d;
    @(negedge clk);
    hv = 0; hw = 0; hd = '0;
    r = host_rdata;
  endtask

  function automatic logic [63:0] ctl(input logic rdf, input logic [3:0] sz, input logic [31:0] a);
    logic [63:0] c;
    c = 64'hFFF0_0000_0000_0000 & 64'h0;
    c[48] = rdf; c[59:56] = sz; c[31:0] = a;
    return c;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (ib_req) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
  end

  initial begin
    logic [63:0] r;
    int n0;
    logic [31:0] lanes;
    repeat (4) @(negedge clk);
    rst = 0;
    // R11: reset state
    acc(0, 2, 0, r); check("R11 reset status", r, 64'h0);
    acc(0, 3, 0, r); check("R11 reset data", r, 64'h0);
    check("R11 reset req", {63'h0, ib_req}, 64'h0);
    // R2: data staging
    acc(1, 3, 64'hA1B2C3D4_1122_3344, r);
    acc(0, 3, 0, r); check("R2 data readback", r, 64'hA1B2C3D4_0000_0000);
    // R1: control/reset read zero, status/reset writes inert
    acc(0, 0, 0, r); check("R1 control read", r, 64'h0);
    acc(0, 1, 0, r); check("R1 reset read", r, 64'h0);
    acc(1, 2, 64'hFFFF_FFFF_FFFF_FFFF, r);
    acc(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, r);
    acc(0, 2, 0, r); check("R1 status after writes", r, 64'h0);
    acc(0, 3, 0, r); check("R1 data after writes", r, 64'hA1B2C3D4_0000_0000);
    // R7/R3: write transaction
    lat = 3;
    acc(1, 0, ctl(0, 4'd4, 32'h0000_0100), r); wait_idle();
    check("R3 captured addr", {32'h0, cap_addr}, 64'h100);
    check("R3 captured size/we", {59'h0, cap_we, cap_size}, {59'h0, 1'b1, 4'd4});
    check("R7 lane order", {32'h0, cap_wdata}, 64'hD4C3B2A1);
    acc(0, 2, 0, r); check("R7 write done", r, 64'h800);
    acc(0, 2, 0, r); check("R8 cleared after read", r, 64'h0);
    // R7: write with error still done
    acc(1, 0, ctl(0, 4'd2, 32'h8000_0004), r); wait_idle();
    acc(0, 2, 0, r); check("R7 write err done", r, 64'h800);
    // R5: read success
    lat = 1;
    acc(1, 0, ctl(1, 4'd4, 32'h0000_0040), r); wait_idle();
    lanes = {8'h40, 8'h41, 8'h42, 8'h43} ^ 32'h5A5A5A5A;
    acc(0, 2, 0, r); check("R5 read data", r, ({32'h0, lanes} << 26) | 64'h800);
    // R6: read error
    acc(1, 0, ctl(1, 4'd4, 32'h8000_0010), r); wait_idle();
    acc(0, 2, 0, r); check("R6 read err", r, 64'h03FF_FFFF_FC00_0800);
    // R4: oversize refused, status kept; size 8 accepted
    acc(1, 0, ctl(0, 4'd1, 32'h20), r); wait_idle();
    n0 = nreq;
    acc(1, 0, ctl(1, 4'd9, 32'h24), r);
    repeat (5) @(negedge clk);
    check("R4 no request", 64'(nreq), 64'(n0));
    acc(0, 2, 0, r); check("R4 status kept", r, 64'h800);
    acc(1, 0, ctl(1, 4'd8, 32'h28), r); wait_idle();
    check("R4 size 8 accepted", {60'h0, cap_size}, 64'h8);
    acc(0, 2, 0, r);
    // R9: control write during flight dropped
    lat = 6; n0 = nreq;
    acc(1, 0, ctl(1, 4'd4, 32'h30), r);
    acc(1, 0, ctl(1, 4'd4, 32'h34), r);
    wait_idle(); repeat (3) @(negedge clk);
    check("R9 single request", 64'(nreq), 64'(n0 + 1));
    check("R9 first addr kept", {32'h0, cap_addr}, 64'h30);
    acc(0, 2, 0, r);
    // R10: status read collides with ack
    acc(1, 0, ctl(0, 4'd1, 32'h50), r); wait_idle();   // leaves status = 0x800
    lat = 3;
    acc(1, 0, ctl(1, 4'd4, 32'h60), r);
    @(negedge clk);
    acc(0, 2, 0, r); check("R10 pre-ack contents", r, 64'h800);
    lanes = {8'h60, 8'h61, 8'h62, 8'h63} ^ 32'h5A5A5A5A;
    acc(0, 2, 0, r); check("R10 completion kept", r, ({32'h0, lanes} << 26) | 64'h800);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule